// File: doc/BRIEF.md
# Pipeline Operand Interlock Unit

This block decides, every cycle, whether the instruction waiting in the register-read issue stage (I2) may move into the first execute stage or must wait because one of its source operands cannot yet be forwarded to it. It keeps its own record of the instructions already in flight in execute stages E1 to E4: for each one, whether it is valid, whether it writes a register, which register it writes, and the stage at the end of which its result exists. For each of the three source slots of the issuing instruction it finds the youngest in-flight writer of that register. It then compares that writer's result stage with the stage at which this consumer, in this slot, needs the value.

The issue side is a valid/ready stream. Decode presents `iss_valid` with a payload (class, sources, destination, write flag, divide length). The instruction is taken on a rising edge where `iss_valid` and `iss_ready` are both high. While `iss_ready` is low the producer must keep `iss_valid` high and the payload unchanged, and `iss_stall` is high. `iss_ready` does not depend on `iss_valid`. Each cycle in which nothing is taken, E1 receives a bubble and everything older keeps moving. The forwarding selects tell the datapath which stage holds the youngest writer of each source, so that it can pick up the value on the way.

Besides data hazards, the unit models two structural holds. A multiply or multiply-accumulate stays in E1 for two cycles. A divide stays in E2 for a number of extra cycles that decode supplies with it.

Top module: `opnd_interlock`

## Requirements
- R1: After reset the in-flight record is empty: with no instruction offered `iss_ready` is 1, `iss_stall` is 0, and all forwarding selects are 0.
- R2: `iss_class` encodes NOP=0, ALU=1, ALU-shift=2, MUL=3, MAC=4, DIV=5, SAD=6, SAD-accumulate=7, LOAD=8, STORE=9, BRANCH=10, MMU=11; other codes act as NOP. The need stage of each slot (a, b, c) is set by the class:
  - ALU and BRANCH: a and b at E2.
  - ALU-shift: a at E2, b at E1.
  - MUL, DIV and SAD: a and b at E1.
  - MAC and SAD-accumulate: a and b at E1, c at E2.
  - LOAD and MMU: a at E1.
  - STORE: a (address) at E1, b (data) at E2.
  - A slot not listed is not read and never causes a stall.
- R3: A producer's result is ready at the end of E3 for LOAD, MUL, MAC, SAD and SAD-accumulate. It is ready at the end of E2 for every other class, including a store's base update and a branch's link address.
- R4: With the youngest matching writer in stage P (E1=1 .. E4=4), ready stage R and need stage N, the slot blocks issue while R + 1 - N - P > 0. With back-to-back issue this gives max(0, R - N) stall cycles.
- R5: `fwd_a`, `fwd_b` and `fwd_c` give the stage number (1 to 4) of the youngest in-flight writer of that slot's register. They are 0 when no in-flight instruction writes it, so the register file supplies it.
- R6: When several in-flight instructions write the same register, the youngest one (the lowest stage number) decides both the stall and the select.
- R7: Source register 0 never matches, and an instruction with `iss_wr`=0 is never a producer.
- R8: Operand role changes the need stage within one instruction. A multiply-accumulate's accumulator (slot c) is needed one stage later than its multiplicands. An ALU-shift's shifted operand (slot b) is needed one stage earlier than slot a.
- R9: MUL and MAC stay in E1 for two cycles, so the next instruction waits at least one cycle.
- R10: A DIV stays in E2 for `iss_e2_extra` extra cycles. An instruction waiting in E1 behind it blocks issue for that long. `iss_e2_extra` is ignored for every other class.
- R11: `iss_stall` equals `iss_valid` and not `iss_ready`. A cycle in which nothing is taken puts a bubble into E1 while the in-flight instructions advance. The payload must be held while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is offered from I2 |
| iss_ready | output | 1 | The offered instruction may enter E1 this edge |
| iss_stall | output | 1 | Offered instruction is held back |
| iss_class | input | 4 | Instruction class code (R2) |
| iss_src_a | input | REG_W | Source register, slot a |
| iss_src_b | input | REG_W | Source register, slot b |
| iss_src_c | input | REG_W | Source register, slot c |
| iss_dst | input | REG_W | Destination register |
| iss_wr | input | 1 | The instruction writes `iss_dst` |
| iss_e2_extra | input | XW | Extra E2 cycles of a divide |
| fwd_a | output | 3 | Forwarding stage for slot a (0 = register file) |
| fwd_b | output | 3 | Forwarding stage for slot b |
| fwd_c | output | 3 | Forwarding stage for slot c |

## Verification
The bench measures stall length at the issue port for each producer/consumer pairing whose result and need stages differ: load to address, load to ALU, ALU to multiplier, and accumulator versus multiplicand. A design that ignored operand role would stall a multiply-accumulate on its accumulator as long as on its multiplicands, or the reverse. It also places two writers of the same register back to back in both orders; picking the older writer shows up as a wrong select or a missing stall. Register 0, unread slots and non-writing stores are offered as false matches, and the gap between producer and consumer is widened one cycle at a time to watch the select walk from E2 to E4 and then to 0. The multiply and divide holds are timed as well: a hold that is one cycle off, or a divide length applied to other classes, changes the stall count.

// File: rtl/oil_pkg.sv
package oil_pkg;

  localparam int STG_W = 3;

  localparam logic [STG_W-1:0] STG_NONE = 3'd0;
  localparam logic [STG_W-1:0] STG_E1   = 3'd1;
  localparam logic [STG_W-1:0] STG_E2   = 3'd2;
  localparam logic [STG_W-1:0] STG_E3   = 3'd3;

  typedef enum logic [3:0] {
    CL_NOP    = 4'd0,
    CL_ALU    = 4'd1,
    CL_SHIFT  = 4'd2,
    CL_MUL    = 4'd3,
    CL_MAC    = 4'd4,
    CL_DIV    = 4'd5,
    CL_SAD    = 4'd6,
    CL_SADA   = 4'd7,
    CL_LOAD   = 4'd8,
    CL_STORE  = 4'd9,
    CL_BRANCH = 4'd10,
    CL_MMU    = 4'd11
  } icls_e;

  // Stage at which a consumer of class c needs the operand in slot s (0 = unread).
  function automatic logic [STG_W-1:0] need_stage(icls_e c, int unsigned s);
    logic [STG_W-1:0] n;
    n = STG_NONE;
    case (c)
      CL_ALU, CL_BRANCH:    if (s < 2) n = STG_E2;
      CL_SHIFT:             n = (s == 0) ? STG_E2 : ((s == 1) ? STG_E1 : STG_NONE);
      CL_MUL, CL_DIV,
      CL_SAD:               if (s < 2) n = STG_E1;
      CL_MAC, CL_SADA:      n = (s == 2) ? STG_E2 : STG_E1;
      CL_LOAD, CL_MMU:      if (s == 0) n = STG_E1;
      CL_STORE:             n = (s == 0) ? STG_E1 : ((s == 1) ? STG_E2 : STG_NONE);
      default:              n = STG_NONE;
    endcase
    return n;
  endfunction

  // Stage at whose end a producer of class c has its result.
  function automatic logic [STG_W-1:0] ready_stage(icls_e c);
    case (c)
      CL_LOAD, CL_MUL, CL_MAC, CL_SAD, CL_SADA: return STG_E3;
      default:                                  return STG_E2;
    endcase
  endfunction

  // Classes that stay in E1 for a second cycle.
  function automatic logic holds_e1(icls_e c);
    return (c == CL_MUL) || (c == CL_MAC);
  endfunction

endpackage

// File: rtl/oil_track.sv
module oil_track #(
  parameter int REG_W = 5,
  parameter int NSTG  = 4,
  parameter int XW    = 6,
  parameter int SW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc,
  input  logic                        in_wr,
  input  logic [REG_W-1:0]            in_dst,
  input  logic [SW-1:0]               in_rdy,
  input  logic                        in_e1x,
  input  logic [XW-1:0]               in_e2x,
  output logic [NSTG:1]               st_prod,
  output logic [NSTG:1][REG_W-1:0]    st_dst,
  output logic [NSTG:1][SW-1:0]       st_rdy,
  output logic                        e1_blocked
);

  logic [NSTG:1]            v, w, nv, nw;
  logic [NSTG:1][REG_W-1:0] d, nd;
  logic [NSTG:1][SW-1:0]    r, nr;
  logic                     x1, nx1;
  logic [XW-1:0]            e2x1, ne2x1;
  logic [XW-1:0]            c2, nc2;
  logic                     hold2;
  logic                     blk1;

  assign hold2 = v[2] && (c2 != '0);
  assign blk1  = v[1] && (x1 || hold2);

  always_comb begin
    nv = v; nw = w; nd = d; nr = r;
    nx1 = x1; ne2x1 = e2x1; nc2 = c2;
    // stages beyond E3 always drain forward
    for (int s = NSTG; s >= 4; s--) begin
      nv[s] = v[s-1];
      nw[s] = w[s-1];
      nd[s] = d[s-1];
      nr[s] = r[s-1];
    end
    // E3 takes a bubble while E2 is held by a divide
    if (hold2) begin
      nv[3] = 1'b0;
    end else begin
      nv[3] = v[2]; nw[3] = w[2]; nd[3] = d[2]; nr[3] = r[2];
    end
    // E2
    if (hold2) begin
      nc2 = c2 - 1'b1;
    end else if (v[1] && !x1) begin
      nv[2] = 1'b1; nw[2] = w[1]; nd[2] = d[1]; nr[2] = r[1];
      nc2 = e2x1;
    end else begin
      nv[2] = 1'b0;
      nc2 = '0;
    end
    // E1
    if (blk1) begin
      nx1 = 1'b0;
    end else if (acc) begin
      nv[1] = 1'b1; nw[1] = in_wr; nd[1] = in_dst; nr[1] = in_rdy;
      nx1 = in_e1x; ne2x1 = in_e2x;
    end else begin
      nv[1] = 1'b0;
      nx1 = 1'b0;
      ne2x1 = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0; w <= '0; d <= '0; r <= '0;
      x1 <= 1'b0; e2x1 <= '0; c2 <= '0;
    end else begin
      v <= nv; w <= nw; d <= nd; r <= nr;
      x1 <= nx1; e2x1 <= ne2x1; c2 <= nc2;
    end
  end

  assign st_prod    = v & w;
  assign st_dst     = d;
  assign st_rdy     = r;
  assign e1_blocked = blk1;

  AST_MUL_HOLDS_E1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_e1x) |=> (v[1] && d[1] == $past(in_dst))); // R9

  AST_DIV_HOLDS_E2: assert property (@(posedge clk) disable iff (!rst_n)
    hold2 |=> (v[2] && d[2] == $past(d[2]))); // R10

  AST_NO_PASS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    hold2 |=> !v[3]); // R10

  AST_BUBBLE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !blk1) |=> !v[1]); // R11

endmodule

// File: rtl/oil_operand.sv
module oil_operand #(
  parameter int REG_W = 5,
  parameter int NSTG  = 4,
  parameter int SW    = 3
) (
  input  logic [REG_W-1:0]         src,
  input  logic [SW-1:0]            need,
  input  logic [NSTG:1]            st_prod,
  input  logic [NSTG:1][REG_W-1:0] st_dst,
  input  logic [NSTG:1][SW-1:0]    st_rdy,
  output logic [SW-1:0]            pos,
  output logic [SW-1:0]            wait_cy
);

  logic          hit;
  logic [SW-1:0] rsel;
  int            gap;

  always_comb begin
    hit  = 1'b0;
    pos  = '0;
    rsel = '0;
    // scan oldest to youngest so the youngest match is the last one kept
    for (int s = NSTG; s >= 1; s--) begin
      if ((need != '0) && (src != '0) && st_prod[s] && (st_dst[s] == src)) begin
        hit  = 1'b1;
        pos  = SW'(s);
        rsel = st_rdy[s];
      end
    end
    gap = int'(rsel) + 1 - int'(need) - int'(pos);
    wait_cy = (hit && gap > 0) ? SW'(gap) : '0;
    AST_ZERO_REG_FREE: assert ((src != '0) || (!hit && wait_cy == '0)); // R7
  end

endmodule

// File: rtl/opnd_interlock.sv
module opnd_interlock #(
  parameter int REG_W = 5,
  parameter int XW    = 6,
  parameter int NSTG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  output logic             iss_ready,
  output logic             iss_stall,
  input  logic [3:0]       iss_class,
  input  logic [REG_W-1:0] iss_src_a,
  input  logic [REG_W-1:0] iss_src_b,
  input  logic [REG_W-1:0] iss_src_c,
  input  logic [REG_W-1:0] iss_dst,
  input  logic             iss_wr,
  input  logic [XW-1:0]    iss_e2_extra,
  output logic [2:0]       fwd_a,
  output logic [2:0]       fwd_b,
  output logic [2:0]       fwd_c
);
  import oil_pkg::*;

  localparam int SW    = STG_W;
  localparam int NSLOT = 3;

  icls_e                    cls;
  logic                     acc;
  logic                     hazard;
  logic                     e1_blk;
  logic [NSTG:1]            st_prod;
  logic [NSTG:1][REG_W-1:0] st_dst;
  logic [NSTG:1][SW-1:0]    st_rdy;
  logic [NSLOT-1:0][REG_W-1:0] srcs;
  logic [NSLOT-1:0][SW-1:0]    pos;
  logic [NSLOT-1:0][SW-1:0]    wcy;

  assign cls  = icls_e'(iss_class);
  assign srcs = {iss_src_c, iss_src_b, iss_src_a};

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [SW-1:0] need_i;
    assign need_i = need_stage(cls, i);
    oil_operand #(.REG_W(REG_W), .NSTG(NSTG), .SW(SW)) u_opnd (
      .src     (srcs[i]),
      .need    (need_i),
      .st_prod (st_prod),
      .st_dst  (st_dst),
      .st_rdy  (st_rdy),
      .pos     (pos[i]),
      .wait_cy (wcy[i])
    );
  end

  always_comb begin
    hazard = 1'b0;
    for (int i = 0; i < NSLOT; i++) hazard = hazard || (wcy[i] != '0);
  end

  assign iss_ready = !e1_blk && !hazard;
  assign iss_stall = iss_valid && !iss_ready;
  assign acc       = iss_valid && iss_ready;

  oil_track #(.REG_W(REG_W), .NSTG(NSTG), .XW(XW), .SW(SW)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (acc),
    .in_wr      (iss_wr),
    .in_dst     (iss_dst),
    .in_rdy     (ready_stage(cls)),
    .in_e1x     (holds_e1(cls)),
    .in_e2x     ((cls == CL_DIV) ? iss_e2_extra : '0),
    .st_prod    (st_prod),
    .st_dst     (st_dst),
    .st_rdy     (st_rdy),
    .e1_blocked (e1_blk)
  );

  assign fwd_a = pos[0];
  assign fwd_b = pos[1];
  assign fwd_c = pos[2];

  AST_HAZARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && hazard) |-> (!iss_ready && iss_stall)); // R4

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stall |=> (iss_valid && $stable(iss_class) && $stable(iss_src_a)
                   && $stable(iss_src_b) && $stable(iss_src_c) && $stable(iss_dst))); // R11

endmodule

// File: tb/opnd_interlock_test.sv
`timescale 1ns/1ps
module opnd_interlock_test;

  localparam int RW = 5;
  localparam int XWD = 6;
  localparam int K_ALU = 1, K_SHIFT = 2, K_MUL = 3, K_MAC = 4, K_DIV = 5;
  localparam int K_SADA = 7, K_LOAD = 8, K_STORE = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready, iss_stall;
  logic [3:0] iss_class = '0;
  logic [RW-1:0] iss_src_a = '0, iss_src_b = '0, iss_src_c = '0, iss_dst = '0;
  logic iss_wr = 1'b0;
  logic [XWD-1:0] iss_e2_extra = '0;
  logic [2:0] fwd_a, fwd_b, fwd_c;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  opnd_interlock #(.REG_W(RW), .XW(XWD), .NSTG(4)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_stall(iss_stall), .iss_class(iss_class), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_src_c(iss_src_c), .iss_dst(iss_dst),
    .iss_wr(iss_wr), .iss_e2_extra(iss_e2_extra),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_c(fwd_c)
  );

  task automatic check(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    iss_valid = 1'b0; iss_class = '0; iss_wr = 1'b0;
    iss_src_a = '0; iss_src_b = '0; iss_src_c = '0; iss_dst = '0; iss_e2_extra = '0;
    repeat (n) @(negedge clk);
  endtask

  // Offer one instruction at a falling edge; return stall cycles and selects at acceptance.
  task automatic send(input int cls, input int a, input int b, input int c,
                      input int dst, input int wr, input int ex,
                      output int st, output int fa, output int fb, output int fc);
    iss_valid = 1'b1; iss_class = 4'(cls);
    iss_src_a = RW'(a); iss_src_b = RW'(b); iss_src_c = RW'(c);
    iss_dst = RW'(dst); iss_wr = (wr != 0); iss_e2_extra = XWD'(ex);
    st = 0;
    #1;
    while (!iss_ready && st < 60) begin
      check("R11", "stall pin while blocked", int'(iss_stall), 1);
      st++;
      @(negedge clk);
      #1;
    end
    fa = int'(fwd_a); fb = int'(fwd_b); fc = int'(fwd_c);
    @(negedge clk);
    iss_valid = 1'b0; iss_wr = 1'b0;
  endtask

  task automatic t_reset();
    int s, fa, fb, fc;
    #1;
    check("R1", "ready after reset", int'(iss_ready), 1);
    check("R1", "stall after reset", int'(iss_stall), 0);
    check("R1", "fwd_a after reset", int'(fwd_a), 0);
    send(K_ALU, 5, 6, 0, 7, 1, 0, s, fa, fb, fc);
    check("R1", "first issue stalls", s, 0);
    check("R1", "first issue select a", fa, 0);
    idle(6);
  endtask

  task automatic t_basic();
    int s, fa, fb, fc;
    send(K_ALU, 0, 0, 0, 5, 1, 0, s, fa, fb, fc);
    send(K_ALU, 5, 0, 0, 1, 1, 0, s, fa, fb, fc);
    check("R4", "alu->alu stalls", s, 0);
    check("R5", "alu->alu select E1", fa, 1);
    idle(6);
    send(K_LOAD, 0, 0, 0, 6, 1, 0, s, fa, fb, fc);
    send(K_ALU, 6, 0, 0, 1, 1, 0, s, fa, fb, fc);
    check("R3", "load->alu stalls", s, 1);
    check("R5", "load->alu select E2", fa, 2);
    idle(6);
    send(K_LOAD, 0, 0, 0, 6, 1, 0, s, fa, fb, fc);
    send(K_LOAD, 6, 0, 0, 2, 1, 0, s, fa, fb, fc);
    check("R2", "load->address stalls", s, 2);
    check("R5", "load->address select E3", fa, 3);
    idle(6);
    send(K_ALU, 0, 0, 0, 7, 1, 0, s, fa, fb, fc);
    send(K_MUL, 0, 7, 0, 2, 1, 0, s, fa, fb, fc);
    check("R2", "alu->mul stalls", s, 1);
    check("R5", "alu->mul select b", fb, 2);
    idle(6);
  endtask

  task automatic t_roles();
    int s, fa, fb, fc;
    send(K_ALU, 0, 0, 0, 7, 1, 0, s, fa, fb, fc);
    send(K_MAC, 3, 4, 7, 8, 1, 0, s, fa, fb, fc);
    check("R8", "alu->mac accumulator stalls", s, 0);
    check("R8", "accumulator select", fc, 1);
    idle(6);
    send(K_ALU, 0, 0, 0, 7, 1, 0, s, fa, fb, fc);
    send(K_MAC, 7, 4, 3, 8, 1, 0, s, fa, fb, fc);
    check("R8", "alu->mac multiplicand stalls", s, 1);
    idle(6);
    send(K_LOAD, 0, 0, 0, 7, 1, 0, s, fa, fb, fc);
    send(K_SADA, 0, 0, 7, 8, 1, 0, s, fa, fb, fc);
    check("R8", "load->sad-acc accumulator stalls", s, 1);
    idle(6);
    send(K_LOAD, 0, 0, 0, 7, 1, 0, s, fa, fb, fc);
    send(K_SADA, 7, 0, 0, 8, 1, 0, s, fa, fb, fc);
    check("R8", "load->sad-acc operand stalls", s, 2);
    idle(6);
    send(K_LOAD, 0, 0, 0, 8, 1, 0, s, fa, fb, fc);
    send(K_SHIFT, 0, 8, 0, 9, 1, 0, s, fa, fb, fc);
    check("R8", "load->shifted operand stalls", s, 2);
    idle(6);
    send(K_LOAD, 0, 0, 0, 8, 1, 0, s, fa, fb, fc);
    send(K_SHIFT, 8, 0, 0, 9, 1, 0, s, fa, fb, fc);
    check("R8", "load->shift other operand stalls", s, 1);
    idle(6);
    send(K_LOAD, 0, 0, 0, 12, 1, 0, s, fa, fb, fc);
    send(K_ALU, 0, 0, 12, 9, 1, 0, s, fa, fb, fc);
    check("R2", "unread slot stalls", s, 0);
    check("R2", "unread slot select", fc, 0);
    idle(6);
  endtask

  task automatic t_false_match();
    int s, fa, fb, fc;
    send(K_LOAD, 0, 0, 0, 0, 1, 0, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R7", "register 0 stalls", s, 0);
    check("R7", "register 0 select", fa, 0);
    idle(6);
    send(K_STORE, 1, 2, 0, 11, 0, 0, s, fa, fb, fc);
    send(K_LOAD, 11, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R7", "non-writing store stalls", s, 0);
    check("R7", "non-writing store select", fa, 0);
    idle(6);
    send(K_STORE, 1, 2, 0, 11, 1, 0, s, fa, fb, fc);
    send(K_LOAD, 11, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R3", "base update->address stalls", s, 1);
    check("R3", "base update select", fa, 2);
    idle(6);
  endtask

  task automatic t_youngest();
    int s, fa, fb, fc;
    send(K_ALU, 0, 0, 0, 9, 1, 0, s, fa, fb, fc);
    send(K_LOAD, 0, 0, 0, 9, 1, 0, s, fa, fb, fc);
    send(K_ALU, 9, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R6", "younger load wins stalls", s, 1);
    check("R6", "younger load wins select", fa, 2);
    idle(6);
    send(K_LOAD, 0, 0, 0, 9, 1, 0, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 9, 1, 0, s, fa, fb, fc);
    send(K_ALU, 9, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R6", "younger alu wins stalls", s, 0);
    check("R6", "younger alu wins select", fa, 1);
    idle(6);
  endtask

  task automatic t_distance();
    int s, fa, fb, fc;
    send(K_LOAD, 0, 0, 0, 10, 1, 0, s, fa, fb, fc);
    idle(1);
    send(K_ALU, 10, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R4", "load gap1 stalls", s, 0);
    check("R5", "load gap1 select", fa, 2);
    idle(6);
    send(K_LOAD, 0, 0, 0, 10, 1, 0, s, fa, fb, fc);
    idle(3);
    send(K_ALU, 10, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R5", "load gap3 select E4", fa, 4);
    idle(6);
    send(K_LOAD, 0, 0, 0, 10, 1, 0, s, fa, fb, fc);
    idle(4);
    send(K_ALU, 10, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R5", "retired producer select", fa, 0);
    idle(6);
  endtask

  task automatic t_mul_hold();
    int s, fa, fb, fc;
    send(K_MUL, 0, 0, 0, 12, 1, 0, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R9", "independent after mul stalls", s, 1);
    idle(6);
    send(K_MAC, 0, 0, 0, 12, 1, 0, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R9", "independent after mac stalls", s, 1);
    idle(6);
    send(K_MUL, 0, 0, 0, 12, 1, 0, s, fa, fb, fc);
    send(K_ALU, 12, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R9", "dependent after mul stalls", s, 2);
    check("R9", "dependent after mul select", fa, 2);
    idle(6);
  endtask

  task automatic t_div_hold();
    int s, fa, fb, fc;
    send(K_DIV, 0, 0, 0, 13, 1, 3, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R10", "first follower of div stalls", s, 0);
    send(K_ALU, 0, 0, 0, 4, 1, 0, s, fa, fb, fc);
    check("R10", "second follower of div stalls", s, 3);
    idle(8);
    send(K_DIV, 0, 0, 0, 13, 1, 2, s, fa, fb, fc);
    send(K_ALU, 13, 0, 0, 3, 1, 0, s, fa, fb, fc);
    check("R10", "div->alu stalls", s, 0);
    check("R10", "div->alu select", fa, 1);
    send(K_ALU, 0, 13, 0, 4, 1, 0, s, fa, fb, fc);
    check("R10", "div dependent in hold stalls", s, 2);
    check("R10", "div dependent in hold select", fb, 2);
    idle(8);
    send(K_ALU, 0, 0, 0, 14, 1, 7, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 3, 1, 0, s, fa, fb, fc);
    send(K_ALU, 0, 0, 0, 4, 1, 0, s, fa, fb, fc);
    check("R10", "extra ignored for alu", s, 0);
    idle(6);
  endtask

  task automatic t_bubble();
    int s, fa, fb, fc;
    send(K_LOAD, 0, 0, 0, 14, 1, 0, s, fa, fb, fc);
    send(K_ALU, 14, 0, 0, 15, 1, 0, s, fa, fb, fc);
    check("R11", "stalled consumer stalls", s, 1);
    send(K_ALU, 15, 0, 0, 16, 1, 0, s, fa, fb, fc);
    check("R11", "consumer entered once select", fa, 1);
    check("R11", "after bubble stalls", s, 0);
    send(K_ALU, 0, 14, 0, 17, 1, 0, s, fa, fb, fc);
    check("R11", "load kept advancing select", fb, 4);
    idle(6);
  endtask

  initial begin
    #750000;
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_roles();
    t_false_match();
    t_youngest();
    t_distance();
    t_mul_hold();
    t_div_hold();
    t_bubble();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule